// File: doc/BRIEF.md
# Double-Buffered Serial Receiver with Overrun Detection

This block is the receive half of a processor-programmed serial port. A serial line is sampled on the ticks of a receive clock. A control word sets that clock to run at 1, 16 or 64 times the bit rate. Each frame has one low start bit, eight data bits sent least significant bit first, and one stop bit. The bits are shifted into an assembly register. Each completed character is then copied into a read buffer, where the processor can fetch it while the next character arrives.

The processor reaches the block through a small parallel port. It has an active-low select, active-low read and write strobes, and a control/data selector. A control write sets the sampling factor and enables reception, and it can clear the error flags. A status read shows whether a character is waiting, whether one was lost to an overrun, and whether a stop bit was seen low. A data read returns the buffered character and clears the ready flag.

The receive clock reaches the block as a single-cycle enable pulse, `rx_tick`, in the system clock domain. The serial input is asynchronous and is passed through a synchronizer.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `rx_rdy` is 0 and a status read returns 0x00.
- R2: With factor 16 or 64, a high-to-low transition on the line starts a wait of half a bit. The start bit is accepted only if the line is still low at that point. A shorter low pulse yields no character. Every later bit is sampled one full bit time after the previous one.
- R3: With factor 1 (control bits [1:0] = 00), every receive tick samples one bit, and a low sample while idle is taken as the start bit.
- R4: Data bits arrive least significant bit first. A data read (a_ctl = 0) returns the eight received bits.
- R5: `rx_rdy` and status bit 0 go to 1 once a character has been moved into the read buffer.
- R6: A data read clears `rx_rdy` and status bit 0.
- R7: If a character completes while the previous one is still unread, status bit 1 (overrun) is set. The buffer then holds the newer character.
- R8: The overrun bit stays set across data reads. It is cleared only by a control write with bit 4 set.
- R9: A low sample in the stop position sets status bit 2 (framing). The character is still delivered and `rx_rdy` is still raised. Bit 2 is cleared by a control write with bit 4 set.
- R10: A status read (a_ctl = 1) changes neither `rx_rdy` nor the buffered character.
- R11: When control bit 2 (receive enable) is 0, no character is assembled and `rx_rdy` stays 0. Control bits [1:0] select the factor: 00 gives 1, 01 gives 16, and 10 or 11 gives 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | One-cycle pulse per receive clock period |
| rxd | input | 1 | Serial data line, idle high |
| cs_n | input | 1 | Active-low select of the processor port |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a_ctl | input | 1 | 1 selects control/status, 0 selects data |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data; 0 when no read is active |
| rx_rdy | output | 1 | A received character is waiting |

## Verification
The bench uses the default parameters: eight data bits, a largest factor of 64 and a two-stage synchronizer. It issues a receive tick every fourth clock, so a full frame at factor 64 costs about 2,600 cycles. All three factors therefore fit in one run. At factor 16, a start glitch only a quarter of a bit long shows that the half-bit check rejects it. Two characters sent back to back without a read create an overrun. A frame driven with its stop bit low creates a framing error. Both error bits are then cleared through the control word.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam logic [1:0] FAC_X1  = 2'b00;
  localparam logic [1:0] FAC_X16 = 2'b01;

  localparam int CTL_EN_BIT   = 2;
  localparam int CTL_CLR_BIT  = 4;
  localparam int ST_RDY_BIT   = 0;
  localparam int ST_OVR_BIT   = 1;
  localparam int ST_FE_BIT    = 2;

  // receive ticks in one bit time for a factor code
  function automatic int unsigned bit_ticks(input logic [1:0] code);
    if (code == FAC_X1)       return 1;
    else if (code == FAC_X16) return 16;
    else                      return 64;
  endfunction

  // ticks to count after the first low sample to reach the bit center
  function automatic int unsigned center_wait(input logic [1:0] code);
    return (bit_ticks(code) / 2) - 1;
  endfunction

endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b1;
        else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
`timescale 1ns/1ps
module rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 en,
  input  logic [1:0]           fac,
  output logic                 char_done,
  output logic [DATA_BITS-1:0] char_data,
  output logic                 stop_ok
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 line_q;
  logic                 done_q;
  logic                 stop_q;

  // named events for the checks below
  logic is_x1, start_seen, at_center;
  assign is_x1      = (fac == FAC_X1);
  assign start_seen = is_x1 ? !line : (line_q && !line);
  assign at_center  = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      line_q <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        state  <= RX_IDLE;
        line_q <= 1'b1;
      end else if (tick) begin
        line_q <= line;
        unique case (state)
          RX_IDLE: if (start_seen) begin
            idx <= '0;
            if (is_x1) begin
              state <= RX_DATA;
              cnt   <= '0;
            end else begin
              state <= RX_START;
              cnt   <= CNT_W'(center_wait(fac));
            end
          end
          RX_START: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (!line) begin
              state <= RX_DATA;
              cnt   <= CNT_W'(bit_ticks(fac) - 1);
            end else state <= RX_IDLE;
          end
          RX_DATA: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              shreg <= {line, shreg[DATA_BITS-1:1]};
              cnt   <= CNT_W'(bit_ticks(fac) - 1);
              if (idx == IDX_W'(DATA_BITS-1)) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              done_q <= 1'b1;
              stop_q <= line;
              state  <= RX_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign char_done = done_q;
  assign char_data = shreg;
  assign stop_ok   = stop_q;

  // R2: a start bit found high at its center sends the receiver back to idle
  p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == RX_START && at_center && line) |=> (state == RX_IDLE));

  // R3: in factor 1 every data-phase tick is a sampling tick
  p_x1_every_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_x1 && tick && state == RX_DATA) |-> (cnt == '0));

  // R11: a disabled receiver completes nothing
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !char_done);
endmodule

// File: rtl/rx_hostif.sv
`timescale 1ns/1ps
module rx_hostif
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 a_ctl,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 char_done,
  input  logic [DATA_BITS-1:0] char_data,
  input  logic                 stop_ok,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 rx_rdy,
  output logic                 rx_en,
  output logic [1:0]           fac
);
  logic                 rd_act, rd_q, rd_pulse, data_rd, stat_rd;
  logic                 ctl_wr, err_clr;
  logic                 rdy_q, ovr_q, fe_q;
  logic [DATA_BITS-1:0] rbuf;
  logic [DATA_BITS-1:0] status;
  logic                 unused_wbits;

  assign rd_act   = !cs_n && !rd_n;
  assign rd_pulse = rd_act && !rd_q;
  assign data_rd  = rd_pulse && !a_ctl;
  assign stat_rd  = rd_pulse && a_ctl;
  assign ctl_wr   = !cs_n && !wr_n && a_ctl;
  assign err_clr  = ctl_wr && wdata[CTL_CLR_BIT];
  assign unused_wbits = ^{wdata[DATA_BITS-1:CTL_CLR_BIT+1], wdata[CTL_CLR_BIT-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rx_en <= 1'b0;
      fac   <= FAC_X1;
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      fe_q  <= 1'b0;
      rbuf  <= '0;
    end else begin
      rd_q <= rd_act;
      if (ctl_wr) begin
        rx_en <= wdata[CTL_EN_BIT];
        fac   <= wdata[1:0];
      end
      if (char_done) begin
        rbuf  <= char_data;
        rdy_q <= 1'b1;
      end else if (data_rd) rdy_q <= 1'b0;
      if (err_clr) ovr_q <= 1'b0;
      else if (char_done && rdy_q && !data_rd) ovr_q <= 1'b1;
      if (err_clr) fe_q <= 1'b0;
      else if (char_done && !stop_ok) fe_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[ST_RDY_BIT] = rdy_q;
    status[ST_OVR_BIT] = ovr_q;
    status[ST_FE_BIT]  = fe_q;
  end

  assign rdata  = rd_act ? (a_ctl ? status : rbuf) : '0;
  assign rx_rdy = rdy_q;

  // R5: a delivered character raises ready
  p_ready_after_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_rdy);

  // R6: a data read with no new arrival drops ready
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !char_done) |=> !rx_rdy);

  // R7: arrival over an unread character records an overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_rdy && !data_rd && !err_clr) |=> ovr_q);

  // R8: overrun is sticky until an error clear
  p_overrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !err_clr) |=> ovr_q);

  // R9: a low stop sample marks a framing error
  p_framing_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !stop_ok && !err_clr) |=> fe_q);

  // R10: status reads leave ready and the buffer untouched
  p_status_read_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !char_done) |=> ($stable(rx_rdy) && $stable(rbuf)));
endmodule

// File: rtl/uart_rx_dbuf.sv
`timescale 1ns/1ps
module uart_rx_dbuf #(
  parameter int DATA_BITS   = 8,
  parameter int MAX_FACTOR  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_tick,
  input  logic                 rxd,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic                 a_ctl,
  input  logic [DATA_BITS-1:0] wdata,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 rx_rdy
);
  localparam int CNT_W = $clog2(MAX_FACTOR);

  logic                 line;
  logic                 char_done, stop_ok, rx_en;
  logic [DATA_BITS-1:0] char_data;
  logic [1:0]           fac;

  rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line)
  );

  rx_deframer #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) deframer_i (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .line(line), .en(rx_en),
    .fac(fac), .char_done(char_done), .char_data(char_data), .stop_ok(stop_ok)
  );

  rx_hostif #(.DATA_BITS(DATA_BITS)) hostif_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .a_ctl(a_ctl), .wdata(wdata), .char_done(char_done),
    .char_data(char_data), .stop_ok(stop_ok), .rdata(rdata),
    .rx_rdy(rx_rdy), .rx_en(rx_en), .fac(fac)
  );
endmodule

// File: tb/uart_rx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_rx_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick;
  logic       rxd = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a_ctl = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rx_rdy;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;   // 125 MHz

  always_ff @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    cycles <= cycles + 1;
  end
  assign rx_tick = (tdiv == 2'd0);

  uart_rx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .a_ctl(a_ctl), .wdata(wdata),
    .rdata(rdata), .rx_rdy(rx_rdy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!rx_tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; a_ctl = 1'b1; wdata = v;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; wdata = 8'h00;
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; a_ctl = sel;
    #1 v = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop_bit, input int n);
    rxd = 1'b0;
    wait_ticks(n);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_ticks(n);
    end
    rxd = stop_bit;
    wait_ticks(n);
    rxd = 1'b1;
    wait_ticks(n + 2);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 ready after reset", {7'd0, rx_rdy}, 8'h00);
    bus_read(1'b1, v);
    check("R1 status after reset", v, 8'h00);
  endtask

  task automatic t_x16_basic;
    logic [7:0] v;
    ctl_write(8'h05);
    send_char(8'hA5, 1'b1, 16);
    check("R5 ready pin", {7'd0, rx_rdy}, 8'h01);
    bus_read(1'b1, v);
    check("R5 status ready", v, 8'h01);
    bus_read(1'b0, v);
    check("R4 x16 data", v, 8'hA5);
    check("R6 ready cleared", {7'd0, rx_rdy}, 8'h00);
    bus_read(1'b1, v);
    check("R6 status cleared", v, 8'h00);
  endtask

  task automatic t_status_keeps;
    logic [7:0] v;
    send_char(8'h3C, 1'b1, 16);
    bus_read(1'b1, v);
    bus_read(1'b1, v);
    check("R10 status twice", v, 8'h01);
    check("R10 ready kept", {7'd0, rx_rdy}, 8'h01);
    bus_read(1'b0, v);
    check("R10 data kept", v, 8'h3C);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    check("R2 glitch rejected", {7'd0, rx_rdy}, 8'h00);
    send_char(8'h5A, 1'b1, 16);
    bus_read(1'b0, v);
    check("R2 resync data", v, 8'h5A);
  endtask

  task automatic t_x1;
    logic [7:0] v;
    ctl_write(8'h04);
    wait_ticks(2);
    send_char(8'h81, 1'b1, 1);
    check("R3 x1 ready", {7'd0, rx_rdy}, 8'h01);
    bus_read(1'b0, v);
    check("R3 x1 data", v, 8'h81);
  endtask

  task automatic t_x64;
    logic [7:0] v;
    ctl_write(8'h06);
    wait_ticks(2);
    send_char(8'h7E, 1'b1, 64);
    bus_read(1'b0, v);
    check("R11 x64 data", v, 8'h7E);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    ctl_write(8'h05);
    wait_ticks(2);
    send_char(8'h11, 1'b1, 16);
    send_char(8'h22, 1'b1, 16);
    bus_read(1'b1, v);
    check("R7 status overrun", v, 8'h03);
    bus_read(1'b0, v);
    check("R7 newest kept", v, 8'h22);
    bus_read(1'b1, v);
    check("R8 overrun sticky", v, 8'h02);
    ctl_write(8'h15);
    bus_read(1'b1, v);
    check("R8 overrun cleared", v, 8'h00);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send_char(8'h44, 1'b0, 16);
    bus_read(1'b1, v);
    check("R9 framing status", v, 8'h05);
    bus_read(1'b0, v);
    check("R9 data delivered", v, 8'h44);
    ctl_write(8'h15);
    bus_read(1'b1, v);
    check("R9 framing cleared", v, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    ctl_write(8'h01);
    send_char(8'h99, 1'b1, 16);
    check("R11 disabled ready", {7'd0, rx_rdy}, 8'h00);
    bus_read(1'b1, v);
    check("R11 disabled status", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_x16_basic();
    t_status_keeps();
    t_glitch();
    t_x1();
    t_x64();
    t_overrun();
    t_framing();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule